// File: doc/BRIEF.md
# Control Endpoint SETUP Drain Engine

This block sits on the bus side of a device controller. It empties the receive FIFO of the control OUT endpoint, which holds typed entries: a control-information word, SETUP data words, a stage-done marker and ordinary OUT data words. In DMA mode it writes data words to memory through a simple valid/ready write port. It drops control-information words without writing them. When it consumes the stage-done marker it raises the SETUP interrupt. In software mode the FIFO head is shown to software, which pops entries with a strobe, and the stage-done marker has the same effect.

The block owns the endpoint-enable bit and the DMA address register. DMA draining only runs while enable is set. Consuming the stage-done marker clears enable again. Any OUT data that follows a consumed SETUP therefore waits in the FIFO until software re-arms the endpoint. The address advances by one word per accepted write, so after a SETUP record the address minus 8 points at the most recent SETUP data. A back-to-back indication from the receive side is kept as a second sticky interrupt bit.

Top module: `setup_drain`

## Requirements
- R1: In DMA mode with enable set, a control-information entry (type code 0) is popped and never written to memory. Each SETUP data entry (type code 1) is written with its data unchanged, at consecutive word addresses starting from the programmed DMA address.
- R2: In DMA mode with enable clear, nothing is popped and no memory write starts. Entries stay in the FIFO, and the sw_pop input has no effect in this mode.
- R3: Popping a stage-done entry (type code 2), by DMA or by software, sets setup_irq from the next cycle on, and setup_irq stays set.
- R4: Popping a stage-done entry clears ep_ena in the next cycle.
- R5: dma_addr grows by 4 on each accepted memory write. After one SETUP record, dma_addr minus 8 equals the address of its first data word. A software address write loads dma_addr in the next cycle.
- R6: An OUT data entry (type code 3) queued behind a consumed stage-done marker is neither popped nor written until software sets enable again. It is then written at the next word address.
- R7: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_addr and mem_data stay unchanged.
- R8: int_clr bit 0 clears setup_irq.
- R9: A pulse on b2b_in sets b2b_irq, which stays set until int_clr bit 1 clears it.
- R10: In software mode, fifo_nempty follows the FIFO valid input, and rd_type and rd_data show the FIFO head. sw_pop pops one entry per cycle, no memory write is made, and the stage-done marker acts as in R3 and R4.
- R11: After reset, ep_ena, setup_irq, b2b_irq, mem_valid and fifo_pop are low and dma_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_mode | input | 1 | 1 = DMA draining, 0 = software pops |
| fifo_valid | input | 1 | Receive FIFO holds at least one entry |
| fifo_type | input | 2 | Type of the FIFO head entry (0 control, 1 SETUP data, 2 stage done, 3 OUT data) |
| fifo_data | input | DATA_W | Data of the FIFO head entry |
| fifo_pop | output | 1 | Removes the FIFO head at this clock edge |
| fifo_nempty | output | 1 | Not-empty status for software, software mode only |
| rd_type | output | 2 | FIFO head type shown to software |
| rd_data | output | DATA_W | FIFO head data shown to software |
| sw_pop | input | 1 | Software pop strobe, software mode only |
| sw_ena_set | input | 1 | Software sets the endpoint enable |
| sw_addr_wr | input | 1 | Software loads the DMA address |
| sw_addr | input | ADDR_W | DMA address value to load |
| int_clr | input | 2 | Write-one-to-clear: bit 0 setup_irq, bit 1 b2b_irq |
| b2b_in | input | 1 | Back-to-back SETUP indication pulse from the receive side |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| ep_ena | output | 1 | Endpoint enable bit |
| dma_addr | output | ADDR_W | Current DMA address register |
| setup_irq | output | 1 | Sticky SETUP-complete interrupt |
| b2b_irq | output | 1 | Sticky back-to-back SETUP interrupt |

## Verification
If the sequencer drained a record while enable was clear, the FIFO would shrink and writes would appear on the memory port within two cycles of the entry reaching the head. If the stage-done marker did not clear enable, the OUT word queued behind it would be written at once instead of waiting. A wrong address step or a control word that was not dropped shows up at once as a write at an unexpected address or with unexpected data. The final dma_addr also misses its record base by a multiple of 4. Broken sticky or clear logic shows on the interrupt outputs in the cycle after the triggering pop, pulse or clear.

// File: rtl/setup_drain_pkg.sv
package setup_drain_pkg;

  typedef enum logic [1:0] {
    ENT_CTRL  = 2'd0,
    ENT_SETUP = 2'd1,
    ENT_DONE  = 2'd2,
    ENT_OUT   = 2'd3
  } entry_t;

  // byte stride of one memory word
  function automatic int unsigned word_bytes(input int unsigned data_w);
    return data_w / 8;
  endfunction

  // entries that carry payload to memory
  function automatic logic is_payload(input entry_t t);
    return (t == ENT_SETUP) || (t == ENT_OUT);
  endfunction

endpackage

// File: rtl/sd_dma_path.sv
module sd_dma_path #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] dma_addr,
  output logic              accept
);
  import setup_drain_pkg::*;

  localparam int unsigned STEP = word_bytes(DATA_W);

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(STEP);
  endfunction

  assign accept = mem_valid && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (load) begin
      mem_valid <= 1'b1;
      mem_addr  <= dma_addr;
      mem_data  <= load_data;
    end else if (accept) begin
      mem_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dma_addr <= '0;
    else if (addr_wr) dma_addr <= addr_val;
    else if (accept)  dma_addr <= advance(dma_addr);
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !addr_wr) |=> (dma_addr == $past(mem_addr) + ADDR_W'(STEP))); // R5

endmodule

// File: rtl/sd_ctrl_regs.sv
module sd_ctrl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ena_set,
  input  logic       done_pop,
  input  logic       b2b_in,
  input  logic [1:0] int_clr,
  output logic       ep_ena,
  output logic       setup_irq,
  output logic       b2b_irq
);

  // sticky bit: a set in the same cycle wins over a clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_ena    <= 1'b0;
      setup_irq <= 1'b0;
      b2b_irq   <= 1'b0;
    end else begin
      ep_ena    <= done_pop ? 1'b0 : (ep_ena | ena_set);
      setup_irq <= sticky_next(setup_irq, done_pop, int_clr[0]);
      b2b_irq   <= sticky_next(b2b_irq, b2b_in, int_clr[1]);
    end
  end

  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_pop |=> setup_irq); // R3
  AST_DONE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    done_pop |=> !ep_ena); // R4
  AST_B2B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (b2b_irq && !int_clr[1]) |=> b2b_irq); // R9

endmodule

// File: rtl/setup_drain.sv
module setup_drain #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_mode,
  input  logic              fifo_valid,
  input  logic [1:0]        fifo_type,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              fifo_nempty,
  output logic [1:0]        rd_type,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sw_pop,
  input  logic              sw_ena_set,
  input  logic              sw_addr_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [1:0]        int_clr,
  input  logic              b2b_in,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              ep_ena,
  output logic [ADDR_W-1:0] dma_addr,
  output logic              setup_irq,
  output logic              b2b_irq
);
  import setup_drain_pkg::*;

  entry_t head_t;
  logic   dma_go;      // DMA may act on the FIFO head this cycle
  logic   ev_load;     // payload word captured into the write port
  logic   ev_drop;     // control word discarded
  logic   ev_done;     // stage-done marker consumed
  logic   ev_accept;   // memory write accepted

  assign head_t = entry_t'(fifo_type);
  assign dma_go = dma_mode && ep_ena && fifo_valid && !mem_valid;

  assign ev_load  = dma_go && is_payload(head_t);
  assign ev_drop  = dma_go && (head_t == ENT_CTRL);
  assign fifo_pop = dma_mode ? (ev_load || ev_drop || (dma_go && head_t == ENT_DONE))
                             : (sw_pop && fifo_valid);
  assign ev_done  = fifo_pop && (head_t == ENT_DONE);

  assign fifo_nempty = fifo_valid && !dma_mode;
  assign rd_type     = fifo_type;
  assign rd_data     = fifo_data;

  sd_dma_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_load),
    .load_data (fifo_data),
    .addr_wr   (sw_addr_wr),
    .addr_val  (sw_addr),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .dma_addr  (dma_addr),
    .accept    (ev_accept)
  );

  sd_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ena_set   (sw_ena_set),
    .done_pop  (ev_done),
    .b2b_in    (b2b_in),
    .int_clr   (int_clr),
    .ep_ena    (ep_ena),
    .setup_irq (setup_irq),
    .b2b_irq   (b2b_irq)
  );

  AST_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && !ep_ena) |-> !fifo_pop); // R2
  AST_CTRL_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && head_t == ENT_CTRL) |=> !$rose(mem_valid)); // R1
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_valid); // R10
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !ev_accept); // R7

endmodule

// File: tb/setup_drain_tb_top.sv
module setup_drain_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dma_mode = 1'b1;
  logic          fifo_valid;
  logic [1:0]    fifo_type;
  logic [DW-1:0] fifo_data;
  logic          fifo_pop, fifo_nempty;
  logic [1:0]    rd_type;
  logic [DW-1:0] rd_data;
  logic          sw_pop = 1'b0, sw_ena_set = 1'b0, sw_addr_wr = 1'b0;
  logic [AW-1:0] sw_addr = '0;
  logic [1:0]    int_clr = 2'b00;
  logic          b2b_in = 1'b0;
  logic          mem_valid, mem_ready = 1'b1;
  logic [AW-1:0] mem_addr, dma_addr;
  logic [DW-1:0] mem_data;
  logic          ep_ena, setup_irq, b2b_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  // FIFO model
  logic [1:0]    q_type [0:31];
  logic [DW-1:0] q_data [0:31];
  int head = 0;
  int tail = 0;
  assign fifo_valid = (head != tail);
  assign fifo_type  = q_type[head % 32];
  assign fifo_data  = q_data[head % 32];
  always @(posedge clk) if (fifo_pop) head <= head + 1;

  // memory capture
  logic [AW-1:0] w_addr [0:31];
  logic [DW-1:0] w_data [0:31];
  int nwr = 0;
  always @(posedge clk) if (mem_valid && mem_ready) begin
    w_addr[nwr % 32] <= mem_addr;
    w_data[nwr % 32] <= mem_data;
    nwr <= nwr + 1;
  end

  setup_drain #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FIFO check FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] t, input logic [DW-1:0] d);
    q_type[tail % 32] = t;
    q_data[tail % 32] = d;
    tail++;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ena();
    sw_ena_set = 1'b1; cyc(1); sw_ena_set = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 ep_ena", ep_ena, 0);
    chk("R11 setup_irq", setup_irq, 0);
    chk("R11 b2b_irq", b2b_irq, 0);
    chk("R11 mem_valid", mem_valid, 0);
    chk("R11 fifo_pop", fifo_pop, 0);
    chk("R11 dma_addr", dma_addr, 0);
  endtask

  task automatic t_gated();
    sw_addr = 32'h0000_1000; sw_addr_wr = 1'b1; cyc(1); sw_addr_wr = 1'b0;
    chk("R5 addr load", dma_addr, 32'h1000);
    push(0, 32'hC0C0_C0C0); push(1, 32'h0605_0080); push(1, 32'h0040_0000); push(2, 32'h0);
    sw_pop = 1'b1; cyc(10); sw_pop = 1'b0;
    chk("R2 fifo untouched", tail - head, 4);
    chk("R2 no writes", nwr, 0);
    chk("R2 irq low", setup_irq, 0);
  endtask

  task automatic t_drain();
    pulse_ena(); cyc(14);
    chk("R1 write count", nwr, 2);
    chk("R1 first addr", w_addr[0], 32'h1000);
    chk("R1 first data", w_data[0], 32'h0605_0080);
    chk("R1 second addr", w_addr[1], 32'h1004);
    chk("R1 second data", w_data[1], 32'h0040_0000);
    chk("R5 last setup ptr", dma_addr - 32'd8, 32'h1000);
    chk("R3 setup_irq", setup_irq, 1);
    chk("R4 ep_ena cleared", ep_ena, 0);
    chk("R1 fifo empty", tail - head, 0);
  endtask

  task automatic t_out_stall();
    push(3, 32'hDA7A_0001); cyc(10);
    chk("R6 out kept", tail - head, 1);
    chk("R6 no write", nwr, 2);
    mem_ready = 1'b0;
    pulse_ena(); cyc(3);
    chk("R7 valid held", mem_valid, 1);
    chk("R7 addr held", mem_addr, 32'h1008);
    chk("R7 data held", mem_data, 32'hDA7A_0001);
    mem_ready = 1'b1; cyc(3);
    chk("R6 out written", nwr, 3);
    chk("R6 out addr", w_addr[2], 32'h1008);
    chk("R5 addr after out", dma_addr, 32'h100C);
  endtask

  task automatic t_irqs();
    int_clr = 2'b01; cyc(1); int_clr = 2'b00;
    chk("R8 setup_irq cleared", setup_irq, 0);
    b2b_in = 1'b1; cyc(1); b2b_in = 1'b0; cyc(3);
    chk("R9 b2b set", b2b_irq, 1);
    int_clr = 2'b10; cyc(1); int_clr = 2'b00;
    chk("R9 b2b cleared", b2b_irq, 0);
  endtask

  task automatic t_soft();
    int nwr0;
    nwr0 = nwr;
    dma_mode = 1'b0;
    chk("R10 nempty low", fifo_nempty, 0);
    push(0, 32'h11); push(1, 32'h22); push(1, 32'h33); push(2, 32'h0);
    pulse_ena(); cyc(4);
    chk("R10 nempty", fifo_nempty, 1);
    chk("R10 no dma pop", tail - head, 4);
    chk("R10 head type", rd_type, 0);
    sw_pop = 1'b1; cyc(1); sw_pop = 1'b0;
    chk("R10 next type", rd_type, 1);
    chk("R10 next data", rd_data, 32'h22);
    sw_pop = 1'b1; cyc(3); sw_pop = 1'b0; cyc(1);
    chk("R10 drained", fifo_nempty, 0);
    chk("R10 no mem write", nwr, nwr0);
    chk("R10/R3 irq", setup_irq, 1);
    chk("R10/R4 ena cleared", ep_ena, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("Watchdog FAIL: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    t_reset();
    t_gated();
    t_drain();
    t_out_stall();
    t_irqs();
    t_soft();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule